// File: doc/BRIEF.md
# I/O Port Select Decoder

This block sits on a processor's local bus and turns direct-I/O port addresses into active-low chip selects for a small group of on-board peripherals: two parallel-port units, a serial unit, a keyboard/display unit, a CRT controller and a disk controller. Three mid-range address bits choose one of eight select lines. The high address bit, the byte-high-enable and every other address bit not used for selection or register choice gate the decoder. Decoding is absolute, so each peripheral answers at exactly one four-register window. The two lowest address bits go unchanged to the chosen peripheral as a register index.

The same block also drives an active-low off-board signal. It goes low for any strobed I/O access that misses the local port map, and for any strobed memory access outside the two local memory windows: RAM from address zero upward and ROM at the top of the space. All outputs are registered. They follow the strobed bus cycle by one clock. Reset is applied asynchronously and released in step with the clock.

Top module: `io_port_select`

## Requirements
- R1: While reset is held, and until the first strobed cycle after it, `sel_n` is 8'hFF, `offboard_n` is 1 and `reg_sel` is 2'b00.
- R2: A cycle with `cyc_stb`=1, `mem_io`=0 (I/O), `bhe_n`=0, address bits [15:6] and [2] equal to those of the base 16'hFF00, and index `addr[5:3]` in 0..5 makes `sel_n[index]` low and every other select high one clock later, with `offboard_n` high.
- R3: At most one bit of `sel_n` is low in any cycle.
- R4: Selects 6 and 7 are reserved and never go low. An otherwise matching I/O access with index 6 or 7 leaves all selects high and drives `offboard_n` low one clock later.
- R5: A strobed I/O access whose bits [15:6] or [2] differ from the base leaves all selects high and drives `offboard_n` low one clock later. This includes any access with A15=0.
- R6: A strobed I/O access with `bhe_n`=1 leaves all selects high and drives `offboard_n` low one clock later.
- R7: A strobed memory cycle (`mem_io`=1) never lowers a select. One clock later `offboard_n` is low exactly when the 20-bit address lies outside 20'h00000..20'h0FFFF and outside 20'hF8000..20'hFFFFF.
- R8: A cycle with `cyc_stb`=0 gives all selects high and `offboard_n` high one clock later, whatever the other inputs are.
- R9: `reg_sel` takes `addr[1:0]` one clock after every strobed cycle, hit or miss, memory or I/O. It holds its value after cycles with `cyc_stb`=0.
- R10: For I/O cycles, bits [19:16] of the address have no effect on the selects or on `offboard_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Bus address; low 16 bits form the port address |
| bhe_n | input | 1 | Active-low byte-high-enable |
| mem_io | input | 1 | Cycle kind: 1 memory, 0 I/O |
| cyc_stb | input | 1 | High during a valid bus cycle |
| sel_n | output | 8 | Active-low peripheral selects |
| reg_sel | output | 2 | Register index passed to the selected peripheral |
| offboard_n | output | 1 | Active-low off-board access indicator |

## Verification
Register-index capture and off-board signalling fall in the same cycle whenever a strobed access misses the local map. The new `reg_sel` and the low `offboard_n` appear together on the same edge. A full sweep of all 65536 port addresses, with varying low bits and upper bits, provokes this on every miss. Each strobed miss is judged against an expected item that carries both the fresh index and the off-board level. Strobe-low cycles placed between strobed ones check that the index holds while off-board returns high.

// File: rtl/io_port_select_pkg.sv
package io_port_select_pkg;
  // Mask of port-address bits that must equal the base for an absolute match:
  // everything except the index field and the register-select field.
  function automatic logic [31:0] fixed_mask(input int port_w, input int idx_lsb,
                                             input int idx_w, input int rs_w);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < port_w; b++) begin
      if (b >= rs_w && !(b >= idx_lsb && b < idx_lsb + idx_w)) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/io_port_select_rst_sync.sv
module io_port_select_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/io_port_select_io_match.sv
module io_port_select_io_match #(
  parameter int          PORT_W  = 16,
  parameter int          IDX_LSB = 3,
  parameter int          IDX_W   = 3,
  parameter int          RS_W    = 2,
  parameter logic [15:0] BASE    = 16'hFF00,
  parameter logic        BHE_ACT = 1'b0
) (
  input  logic [PORT_W-1:0] port_addr,
  input  logic              bhe_n,
  output logic              match,
  output logic [IDX_W-1:0]  idx
);
  import io_port_select_pkg::*;
  localparam logic [PORT_W-1:0] MASK = PORT_W'(fixed_mask(PORT_W, IDX_LSB, IDX_W, RS_W));
  localparam logic [PORT_W-1:0] REF  = PORT_W'(BASE) & MASK;

  always_comb begin
    match = ((port_addr & MASK) == REF) && (bhe_n == BHE_ACT);
    idx   = port_addr[IDX_LSB +: IDX_W];
  end
endmodule

// File: rtl/io_port_select_sel_gen.sv
module io_port_select_sel_gen #(
  parameter int                NUM_SEL = 8,
  parameter int                IDX_W   = 3,
  parameter logic [NUM_SEL-1:0] PRESENT = 8'h3F
) (
  input  logic               en,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_SEL-1:0] hit,
  output logic               any_hit
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    if (PRESENT[i]) begin : g_live
      assign hit[i] = en && (idx == IDX_W'(i));
    end else begin : g_rsvd
      assign hit[i] = 1'b0;
    end
  end
  assign any_hit = |hit;
endmodule

// File: rtl/io_port_select_mem_window.sv
module io_port_select_mem_window #(
  parameter int                ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 20'h0FFFF,
  parameter logic [ADDR_W-1:0] ROM_BASE = 20'hF8000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              local_hit
);
  always_comb local_hit = (addr <= RAM_TOP) || (addr >= ROM_BASE);
endmodule

// File: rtl/io_port_select.sv
module io_port_select #(
  parameter int                 ADDR_W      = 20,
  parameter int                 PORT_W      = 16,
  parameter int                 NUM_SEL     = 8,
  parameter int                 IDX_LSB     = 3,
  parameter int                 RS_W        = 2,
  parameter logic [15:0]        PORT_BASE   = 16'hFF00,
  parameter logic               BHE_ACT     = 1'b0,
  parameter logic [NUM_SEL-1:0] SEL_PRESENT = 8'h3F,
  parameter logic [ADDR_W-1:0]  RAM_TOP     = 20'h0FFFF,
  parameter logic [ADDR_W-1:0]  ROM_BASE    = 20'hF8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bhe_n,
  input  logic               mem_io,
  input  logic               cyc_stb,
  output logic [NUM_SEL-1:0] sel_n,
  output logic [RS_W-1:0]    reg_sel,
  output logic               offboard_n
);
  localparam int IDX_W = $clog2(NUM_SEL);

  logic               srst_n;
  logic               io_match, mem_hit, any_hit, io_cyc;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SEL-1:0] hit;
  logic [NUM_SEL-1:0] sel_d;
  logic [RS_W-1:0]    rs_d;
  logic               off_d;
  logic               rs_en;

  io_port_select_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  io_port_select_io_match #(
    .PORT_W(PORT_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .RS_W(RS_W),
    .BASE(PORT_BASE), .BHE_ACT(BHE_ACT)
  ) u_match (
    .port_addr(bus_addr[PORT_W-1:0]), .bhe_n(bhe_n), .match(io_match), .idx(idx)
  );

  io_port_select_sel_gen #(
    .NUM_SEL(NUM_SEL), .IDX_W(IDX_W), .PRESENT(SEL_PRESENT)
  ) u_sel (
    .en(io_cyc && io_match), .idx(idx), .hit(hit), .any_hit(any_hit)
  );

  io_port_select_mem_window #(
    .ADDR_W(ADDR_W), .RAM_TOP(RAM_TOP), .ROM_BASE(ROM_BASE)
  ) u_mem (
    .addr(bus_addr), .local_hit(mem_hit)
  );

  // Next-state logic
  always_comb begin
    io_cyc = cyc_stb && !mem_io;
    sel_d  = ~hit;
    off_d  = !(cyc_stb && (mem_io ? !mem_hit : !any_hit));
    rs_en  = cyc_stb;
    rs_d   = bus_addr[RS_W-1:0];
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_n      <= '1;
      offboard_n <= 1'b1;
    end else begin
      sel_n      <= sel_d;
      offboard_n <= off_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      reg_sel <= '0;
    end else if (rs_en) begin
      reg_sel <= rs_d;
    end
  end
endmodule

// File: rtl/io_port_select_chk.sv
module io_port_select_chk #(
  parameter int                 NUM_SEL     = 8,
  parameter int                 RS_W        = 2,
  parameter logic [NUM_SEL-1:0] SEL_PRESENT = 8'h3F
) (
  input logic               clk,
  input logic               srst_n,
  input logic               mem_io,
  input logic               cyc_stb,
  input logic               bhe_n,
  input logic [NUM_SEL-1:0] sel_n,
  input logic [RS_W-1:0]    reg_sel,
  input logic               offboard_n
);
  p_one_sel_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(~sel_n));

  p_rsvd_high_r4: assert property (@(posedge clk) disable iff (!srst_n)
    &(sel_n | SEL_PRESENT));

  p_bhe_gate_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_stb && !mem_io && bhe_n) |=> (&sel_n && !offboard_n));

  p_mem_no_sel_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_stb && mem_io) |=> &sel_n);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !cyc_stb |=> (&sel_n && offboard_n));

  p_rs_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !cyc_stb |=> $stable(reg_sel));

  p_sel_excl_off_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !(&sel_n) |-> offboard_n);
endmodule

bind io_port_select io_port_select_chk #(
  .NUM_SEL(NUM_SEL), .RS_W(RS_W), .SEL_PRESENT(SEL_PRESENT)
) u_chk (
  .clk(clk), .srst_n(srst_n), .mem_io(mem_io), .cyc_stb(cyc_stb), .bhe_n(bhe_n),
  .sel_n(sel_n), .reg_sel(reg_sel), .offboard_n(offboard_n)
);

// File: tb/io_port_select_test.sv
module io_port_select_test;
  typedef struct {
    logic [7:0] sel_n;
    logic       off_n;
    logic [1:0] rs;
    string      tag;
  } exp_t;

  logic        clk, rst_n;
  logic [19:0] bus_addr;
  logic        bhe_n, mem_io, cyc_stb;
  logic [7:0]  sel_n;
  logic [1:0]  reg_sel;
  logic        offboard_n;

  int   n_chk, n_fail, n_multi;
  exp_t q[$];
  logic [1:0] last_rs;
  bit   done;

  io_port_select uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bhe_n(bhe_n), .mem_io(mem_io),
    .cyc_stb(cyc_stb), .sel_n(sel_n), .reg_sel(reg_sel), .offboard_n(offboard_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle and push the expected registered result.
  task automatic drive(input logic [19:0] a, input logic bhe, input logic mio,
                       input logic stb, input string tag);
    exp_t e;
    logic match, hit;
    int   idx;
    @(negedge clk);
    bus_addr = a; bhe_n = bhe; mem_io = mio; cyc_stb = stb;
    idx   = int'(a[5:3]);
    match = ((a[15:0] & 16'hFFC4) == 16'hFF00) && !bhe;
    hit   = match && idx < 6;
    e.sel_n = 8'hFF;
    e.off_n = 1'b1;
    if (stb) begin
      last_rs = a[1:0];
      if (mio) e.off_n = (a <= 20'h0FFFF) || (a >= 20'hF8000);
      else begin
        if (hit) e.sel_n[idx] = 1'b0;
        e.off_n = hit;
      end
    end
    e.rs  = last_rs;
    e.tag = tag;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  // Monitor: compare one expected item per cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if ($countones(~sel_n) > 1) n_multi++;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(sel_n == e.sel_n && offboard_n == e.off_n && reg_sel == e.rs, e.tag,
              $sformatf("sel_n=%h off_n=%b rs=%0d", sel_n, offboard_n, reg_sel),
              $sformatf("sel_n=%h off_n=%b rs=%0d", e.sel_n, e.off_n, e.rs));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; n_multi = 0; last_rs = 2'b00; done = 0;
    rst_n = 1'b0; bus_addr = '0; bhe_n = 1'b0; mem_io = 1'b0; cyc_stb = 1'b0;
    repeat (3) @(negedge clk);
    check(sel_n == 8'hFF && offboard_n && reg_sel == 2'b00, "R1 in reset",
          $sformatf("%h %b %0d", sel_n, offboard_n, reg_sel), "ff 1 0");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sel_n == 8'hFF && offboard_n && reg_sel == 2'b00, "R1 after release",
          $sformatf("%h %b %0d", sel_n, offboard_n, reg_sel), "ff 1 0");

    // R2: each populated select at each register index
    for (int i = 0; i < 6; i++)
      for (int r = 0; r < 4; r++)
        drive({4'h0, 16'hFF00 | 16'(i << 3) | 16'(r)}, 1'b0, 1'b0, 1'b1, "R2 hit");
    // R4: reserved indices
    drive({4'h0, 16'hFF30}, 1'b0, 1'b0, 1'b1, "R4 index6");
    drive({4'h0, 16'hFF3B}, 1'b0, 1'b0, 1'b1, "R4 index7");
    // R5: absolute mismatches, including A15 low and A2 high
    drive({4'h0, 16'h7F08}, 1'b0, 1'b0, 1'b1, "R5 A15 low");
    drive({4'h0, 16'hFF0C}, 1'b0, 1'b0, 1'b1, "R5 A2 high");
    drive({4'h0, 16'hFE10}, 1'b0, 1'b0, 1'b1, "R5 A8 low");
    // R6: byte-high-enable inactive
    drive({4'h0, 16'hFF08}, 1'b1, 1'b0, 1'b1, "R6 bhe high");
    // R8 and R9: idle cycles hold the index and stay quiet
    drive({4'h0, 16'hFF13}, 1'b0, 1'b0, 1'b1, "R9 capture");
    drive({4'h0, 16'hFF10}, 1'b0, 1'b0, 1'b0, "R8 R9 idle hold");
    drive(20'hFFFFE, 1'b0, 1'b1, 1'b0, "R8 idle mem");
    drive({4'h0, 16'h1232}, 1'b0, 1'b0, 1'b1, "R9 miss capture");
    // R7: memory windows and their edges
    drive(20'h00000, 1'b0, 1'b1, 1'b1, "R7 ram low");
    drive(20'h0FFFF, 1'b0, 1'b1, 1'b1, "R7 ram top");
    drive(20'h10000, 1'b0, 1'b1, 1'b1, "R7 above ram");
    drive(20'h80001, 1'b0, 1'b1, 1'b1, "R7 middle");
    drive(20'hF7FFF, 1'b0, 1'b1, 1'b1, "R7 below rom");
    drive(20'hF8000, 1'b0, 1'b1, 1'b1, "R7 rom base");
    drive(20'hFFFFF, 1'b0, 1'b1, 1'b1, "R7 rom top");
    drive({4'h0, 16'hFF08}, 1'b0, 1'b1, 1'b1, "R7 port pattern as memory");
    // R10: upper bits on I/O cycles are ignored
    drive({4'h5, 16'hFF18}, 1'b0, 1'b0, 1'b1, "R10 upper bits hit");
    drive({4'hF, 16'hFE18}, 1'b0, 1'b0, 1'b1, "R10 upper bits miss");
    // Full port sweep (R2 R4 R5), strobe gaps every 256 addresses (R8)
    for (int a = 0; a < 65536; a++) begin
      drive({4'(a >> 12), 16'(a)}, 1'b0, 1'b0, 1'b1, "R2 R4 R5 sweep");
      if ((a & 255) == 255) drive(20'h0, 1'b0, 1'b0, 1'b0, "R8 sweep gap");
    end
    repeat (3) @(negedge clk);
    check(n_multi == 0, "R3 single select", $sformatf("%0d", n_multi), "0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule